// File: doc/BRIEF.md
# Link Control Packet Generator

This block forms the short, fixed-size control packets that a link layer exchanges with its immediate partner. These packets never travel past the partner on the other end of the link. Three request ports feed the block: one for acknowledge and negative-acknowledge packets, one for flow-control credit updates and one for power-management packets. Each port carries the fields that belong to its packet type.

When one or more requests are pending and the output is free, the block picks a request by fixed priority and captures that request's fields. From them it builds four bytes: a type byte followed by three body bytes. It appends a 16-bit CRC computed over those four bytes and streams all six bytes out on a byte-wide valid/ready interface. A packet that has started always runs to its last byte. The cycle after the last byte is accepted, a done pulse is returned on the granted request port. The requester drops its request in response to that pulse.

The block does not add physical framing characters, does not decide when an acknowledge is due and does not account for flow-control credits.

Top module: `lctl_pkt_gen`

## Requirements
- R1: While reset is high and in the first idle cycle after it, `tx_valid` and all three done outputs are low.
- R2: Every packet is exactly six accepted bytes, sent type byte first. `tx_last` is high on the sixth byte only.
- R3: An acknowledge packet has type byte 0x00, and a negative acknowledge (`ack_nak`=1) has 0x10. Byte 1 is 0x00, byte 2 is {4'h0, seq[11:8]} and byte 3 is seq[7:0].
- R4: A flow-control packet has type byte {2'b10, kind[1:0], 1'b0, vc[2:0]}, so its upper nibble is 0x8 to 0xB. Byte 1 is the 8-bit header credit, byte 2 is {4'h0, data[11:8]} and byte 3 is data[7:0].
- R5: A power-management packet has type byte 0x20 + code and body bytes 0x00, 0x00, 0x00.
- R6: Bytes 4 and 5 are the high and low bytes of the bitwise inverse of a CRC-16 over bytes 0 to 3. The CRC uses polynomial 0x100B, starts from 0xFFFF and takes each byte MSB first.
- R7: When requests are pending together, the acknowledge port wins over flow control, and flow control wins over power management.
- R8: A packet that has begun is sent to its end before any other request is granted, even one of higher priority.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` keep their values.
- R10: One cycle after the last byte is accepted, exactly one done output pulses high for one cycle: the one belonging to the port whose packet was sent.
- R11: Request fields are captured in the grant cycle. Changing them later has no effect on the packet in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_req | input | 1 | Acknowledge packet requested, held until ack_done |
| ack_nak | input | 1 | 1 selects negative acknowledge |
| ack_seq | input | 12 | Sequence number to report |
| ack_done | output | 1 | Acknowledge packet fully accepted |
| fc_req | input | 1 | Flow-control update requested, held until fc_done |
| fc_kind | input | 2 | Flow-control update kind (type upper nibble minus 8) |
| fc_vc | input | 3 | Virtual channel |
| fc_hdr_cred | input | 8 | Header credit value |
| fc_data_cred | input | 12 | Data credit value |
| fc_done | output | 1 | Flow-control packet fully accepted |
| pm_req | input | 1 | Power-management packet requested, held until pm_done |
| pm_code | input | 3 | Power-management code, 0 to 4 |
| pm_done | output | 1 | Power-management packet fully accepted |
| tx_data | output | 8 | Output byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_last | output | 1 | Final byte of packet |

## Verification
Two things can coincide here: several request ports can be high in the same cycle, and a new request can arrive while the output stream is stalled by back-pressure mid-packet. The bench raises all three requests on one edge, and also raises flow control and power management together. It then judges the order in which the six-byte packets come out and which done output pulses after each. A separate scenario raises the acknowledge request while a power-management packet is halfway out under a stalling ready pattern. That packet must finish unbroken, with its bytes held steady through every stall, before the acknowledge packet appears.

// File: rtl/lctl_pkg.sv
package lctl_pkg;

    localparam int PKT_BYTES  = 6;
    localparam int BODY_BYTES = 4;
    localparam int IDX_W      = $clog2(PKT_BYTES);

    localparam logic [15:0] CRC_POLY = 16'h100B;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    localparam logic [7:0] TYPE_ACK     = 8'h00;
    localparam logic [7:0] TYPE_NAK     = 8'h10;
    localparam logic [7:0] TYPE_PM_BASE = 8'h20;
    localparam logic [1:0] FC_MARK      = 2'b10;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_ACK  = 2'd1,
        CLS_FC   = 2'd2,
        CLS_PM   = 2'd3
    } cls_e;

    typedef struct packed {
        logic [7:0]  kind;
        logic [23:0] body;
    } ctl_head_t;

    // index 0 is the first byte on the wire
    typedef logic [PKT_BYTES-1:0][7:0] pkt_t;

    function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/lctl_arb.sv
module lctl_arb
    import lctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack_req,
    input  logic fc_req,
    input  logic pm_req,
    input  logic busy,
    input  logic settle,
    output cls_e win,
    output logic fire
);

    always_comb begin
        win = CLS_NONE;
        if (!busy && !settle) begin
            if (ack_req)     win = CLS_ACK;
            else if (fc_req) win = CLS_FC;
            else if (pm_req) win = CLS_PM;
        end
    end

    assign fire = (win != CLS_NONE);

    // R7
    pm_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (win == CLS_PM) |-> (!ack_req && !fc_req));

    // R7
    fc_below_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (win == CLS_FC) |-> !ack_req);

endmodule

// File: rtl/lctl_fmt.sv
module lctl_fmt
    import lctl_pkg::*;
#(
    parameter int SEQ_W  = 12,
    parameter int VC_W   = 3,
    parameter int HDR_W  = 8,
    parameter int DAT_W  = 12,
    parameter int PM_W   = 3,
    parameter int KIND_W = 2
) (
    input  cls_e              sel,
    input  logic              ack_nak,
    input  logic [SEQ_W-1:0]  seq,
    input  logic [KIND_W-1:0] fc_kind,
    input  logic [VC_W-1:0]   fc_vc,
    input  logic [HDR_W-1:0]  fc_hdr,
    input  logic [DAT_W-1:0]  fc_dat,
    input  logic [PM_W-1:0]   pm_code,
    output pkt_t              pkt
);

    ctl_head_t   head;
    logic [15:0] crc;
    logic [BODY_BYTES-1:0][7:0] first4;

    always_comb begin
        head = '0;
        case (sel)
            CLS_ACK: begin
                head.kind = ack_nak ? TYPE_NAK : TYPE_ACK;
                head.body = {8'h00, 16'(seq)};
            end
            CLS_FC: begin
                head.kind = {FC_MARK, 2'(fc_kind), 1'b0, 3'(fc_vc)};
                head.body = {8'(fc_hdr), 16'(fc_dat)};
            end
            CLS_PM: begin
                head.kind = TYPE_PM_BASE + 8'(pm_code);
                head.body = '0;
            end
            default: head = '0;
        endcase
    end

    always_comb begin
        first4[0] = head.kind;
        first4[1] = head.body[23:16];
        first4[2] = head.body[15:8];
        first4[3] = head.body[7:0];
        crc = CRC_SEED;
        for (int k = 0; k < BODY_BYTES; k++) crc = crc_byte(crc, first4[k]);
    end

    for (genvar g = 0; g < BODY_BYTES; g++) begin : g_body
        assign pkt[g] = first4[g];
    end
    assign pkt[BODY_BYTES]   = ~crc[15:8];
    assign pkt[BODY_BYTES+1] = ~crc[7:0];

endmodule

// File: rtl/lctl_ser.sv
module lctl_ser
    import lctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  cls_e       load_cls,
    input  pkt_t       load_pkt,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    output logic       tx_last,
    output logic       busy,
    output logic       done,
    output cls_e       done_cls
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

    pkt_t             pkt_q;
    logic [IDX_W-1:0] idx_q;
    logic             valid_q;
    cls_e             cls_q;
    logic             done_q;
    cls_e             done_cls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_q      <= '0;
            idx_q      <= '0;
            valid_q    <= 1'b0;
            cls_q      <= CLS_NONE;
            done_q     <= 1'b0;
            done_cls_q <= CLS_NONE;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                pkt_q   <= load_pkt;
                idx_q   <= '0;
                valid_q <= 1'b1;
                cls_q   <= load_cls;
            end else if (valid_q && tx_ready) begin
                if (idx_q == LAST_IDX) begin
                    valid_q    <= 1'b0;
                    done_q     <= 1'b1;
                    done_cls_q <= cls_q;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign tx_data  = pkt_q[idx_q];
    assign tx_valid = valid_q;
    assign tx_last  = valid_q && (idx_q == LAST_IDX);
    assign busy     = valid_q;
    assign done     = done_q;
    assign done_cls = done_cls_q;

    // R9
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R8
    no_abandon_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !(tx_ready && tx_last)) |=> tx_valid);

    // R10
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> done);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/lctl_pkt_gen.sv
module lctl_pkt_gen
    import lctl_pkg::*;
#(
    parameter int SEQ_W = 12,
    parameter int VC_W  = 3,
    parameter int HDR_W = 8,
    parameter int DAT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_req,
    input  logic             ack_nak,
    input  logic [SEQ_W-1:0] ack_seq,
    output logic             ack_done,
    input  logic             fc_req,
    input  logic [1:0]       fc_kind,
    input  logic [VC_W-1:0]  fc_vc,
    input  logic [HDR_W-1:0] fc_hdr_cred,
    input  logic [DAT_W-1:0] fc_data_cred,
    output logic             fc_done,
    input  logic             pm_req,
    input  logic [2:0]       pm_code,
    output logic             pm_done,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             tx_last
);

    cls_e win;
    logic fire;
    logic busy;
    logic done;
    cls_e done_cls;
    pkt_t pkt;

    lctl_arb u_arb (
        .clk    (clk),
        .rst    (rst),
        .ack_req(ack_req),
        .fc_req (fc_req),
        .pm_req (pm_req),
        .busy   (busy),
        .settle (done),
        .win    (win),
        .fire   (fire)
    );

    lctl_fmt #(
        .SEQ_W (SEQ_W),
        .VC_W  (VC_W),
        .HDR_W (HDR_W),
        .DAT_W (DAT_W),
        .PM_W  (3),
        .KIND_W(2)
    ) u_fmt (
        .sel    (win),
        .ack_nak(ack_nak),
        .seq    (ack_seq),
        .fc_kind(fc_kind),
        .fc_vc  (fc_vc),
        .fc_hdr (fc_hdr_cred),
        .fc_dat (fc_data_cred),
        .pm_code(pm_code),
        .pkt    (pkt)
    );

    lctl_ser u_ser (
        .clk     (clk),
        .rst     (rst),
        .load    (fire),
        .load_cls(win),
        .load_pkt(pkt),
        .tx_ready(tx_ready),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tx_last (tx_last),
        .busy    (busy),
        .done    (done),
        .done_cls(done_cls)
    );

    assign ack_done = done && (done_cls == CLS_ACK);
    assign fc_done  = done && (done_cls == CLS_FC);
    assign pm_done  = done && (done_cls == CLS_PM);

    // R10
    one_done_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ack_done, fc_done, pm_done}));

    // R8
    no_grant_midpkt_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_last) |=> tx_valid);

endmodule

// File: tb/lctl_pkt_gen_bench.sv
`timescale 1ns/1ps
module lctl_pkt_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ack_req = 0, ack_nak = 0;
    logic [11:0] ack_seq = 0;
    logic        fc_req = 0;
    logic [1:0]  fc_kind = 0;
    logic [2:0]  fc_vc = 0;
    logic [7:0]  fc_hdr_cred = 0;
    logic [11:0] fc_data_cred = 0;
    logic        pm_req = 0;
    logic [2:0]  pm_code = 0;
    logic        tx_ready = 1;
    logic        ack_done, fc_done, pm_done;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lctl_pkt_gen u_lctl_pkt_gen (
        .clk(clk), .rst(rst),
        .ack_req(ack_req), .ack_nak(ack_nak), .ack_seq(ack_seq), .ack_done(ack_done),
        .fc_req(fc_req), .fc_kind(fc_kind), .fc_vc(fc_vc), .fc_hdr_cred(fc_hdr_cred),
        .fc_data_cred(fc_data_cred), .fc_done(fc_done),
        .pm_req(pm_req), .pm_code(pm_code), .pm_done(pm_done),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3);
        logic [15:0] c;
        logic [31:0] w;
        c = 16'hFFFF;
        w = {b0, b1, b2, b3};
        for (int i = 31; i >= 0; i--) begin
            if (c[15] ^ w[i]) c = {c[14:0], 1'b0} ^ 16'h100B;
            else              c = {c[14:0], 1'b0};
        end
        return {b0, b1, b2, b3, ~c};
    endfunction

    // cls: 1 ack, 2 flow control, 3 power management
    task automatic collect(input logic [47:0] exp, input int cls, input logic [7:0] pat,
                           input int raise_at, input string rq);
        int   idx = 0;
        int   k = 0;
        logic stall = 0;
        logic [7:0] held = 0;
        while (idx < 6 && k < 300) begin
            @(negedge clk);
            tx_ready = pat[k % 8];
            k++;
            #1;
            if (stall) chk(tx_valid && tx_data == held, "R9 hold", {tx_valid, tx_data}, {1'b1, held});
            if (tx_valid && tx_ready) begin
                chk(tx_data == exp[47-8*idx -: 8], rq, tx_data, exp[47-8*idx -: 8]);
                chk(tx_last == (idx == 5), "R2 last flag", tx_last, idx == 5);
                idx++;
                if (idx == raise_at) ack_req = 1;
            end
            stall = tx_valid && !tx_ready;
            held  = tx_data;
        end
        chk(idx == 6, "R2 byte count", idx, 6);
        @(negedge clk);
        tx_ready = 1;
        #1;
        chk({ack_done, fc_done, pm_done} == {cls == 1, cls == 2, cls == 3}, "R10 done port",
            {ack_done, fc_done, pm_done}, {cls == 1, cls == 2, cls == 3});
        chk(!tx_valid, "R8 no overlap with done", tx_valid, 0);
        if (cls == 1) ack_req = 0;
        if (cls == 2) fc_req = 0;
        if (cls == 3) pm_req = 0;
        @(negedge clk);
        #1;
        chk({ack_done, fc_done, pm_done} == 3'b000, "R10 single pulse", {ack_done, fc_done, pm_done}, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk(!tx_valid && !ack_done && !fc_done && !pm_done, "R1 in reset", {tx_valid, ack_done, fc_done, pm_done}, 0);
        rst = 0;
        @(negedge clk);
        #1;
        chk(!tx_valid && !ack_done && !fc_done && !pm_done, "R1 idle", {tx_valid, ack_done, fc_done, pm_done}, 0);
    endtask

    task automatic t_ack();
        @(negedge clk);
        ack_nak = 0; ack_seq = 12'h123; ack_req = 1;
        collect(mk(8'h00, 8'h00, 8'h01, 8'h23), 1, 8'hFF, -1, "R3 R6 ack bytes");
    endtask

    task automatic t_nak_stall();
        @(negedge clk);
        ack_nak = 1; ack_seq = 12'hABC; ack_req = 1;
        collect(mk(8'h10, 8'h00, 8'h0A, 8'hBC), 1, 8'b0110_1001, -1, "R3 R6 R9 nak bytes");
    endtask

    task automatic t_fc();
        @(negedge clk);
        fc_kind = 2'd2; fc_vc = 3'd5; fc_hdr_cred = 8'h3C; fc_data_cred = 12'h7E1; fc_req = 1;
        collect(mk(8'hA5, 8'h3C, 8'h07, 8'hE1), 2, 8'hFF, -1, "R4 R6 flow control bytes");
    endtask

    task automatic t_pm();
        @(negedge clk);
        pm_code = 3'd3; pm_req = 1;
        collect(mk(8'h23, 8'h00, 8'h00, 8'h00), 3, 8'b1011_0111, -1, "R5 R6 power mgmt bytes");
    endtask

    task automatic t_all_three();
        @(negedge clk);
        ack_nak = 0; ack_seq = 12'hFFF;
        fc_kind = 2'd0; fc_vc = 3'd0; fc_hdr_cred = 8'h01; fc_data_cred = 12'h040;
        pm_code = 3'd4;
        ack_req = 1; fc_req = 1; pm_req = 1;
        collect(mk(8'h00, 8'h00, 8'h0F, 8'hFF), 1, 8'hFF, -1, "R7 first is ack");
        collect(mk(8'h80, 8'h01, 8'h00, 8'h40), 2, 8'hFF, -1, "R7 second is flow control");
        collect(mk(8'h24, 8'h00, 8'h00, 8'h00), 3, 8'hFF, -1, "R7 third is power mgmt");
    endtask

    task automatic t_fc_pm();
        @(negedge clk);
        fc_kind = 2'd3; fc_vc = 3'd7; fc_hdr_cred = 8'hFF; fc_data_cred = 12'hFFF;
        pm_code = 3'd0;
        fc_req = 1; pm_req = 1;
        collect(mk(8'hB7, 8'hFF, 8'h0F, 8'hFF), 2, 8'b1101_1101, -1, "R7 flow control before pm");
        collect(mk(8'h20, 8'h00, 8'h00, 8'h00), 3, 8'hFF, -1, "R7 pm after flow control");
    endtask

    task automatic t_no_preempt();
        @(negedge clk);
        pm_code = 3'd1; pm_req = 1;
        ack_nak = 1; ack_seq = 12'h055;
        collect(mk(8'h21, 8'h00, 8'h00, 8'h00), 3, 8'b0101_1011, 2, "R8 pm runs to end");
        collect(mk(8'h10, 8'h00, 8'h00, 8'h55), 1, 8'hFF, -1, "R8 ack follows");
    endtask

    task automatic t_capture();
        @(negedge clk);
        ack_nak = 0; ack_seq = 12'h9D2; ack_req = 1;
        @(posedge clk);
        #1;
        ack_nak = 1; ack_seq = 12'h000;
        collect(mk(8'h00, 8'h00, 8'h09, 8'hD2), 1, 8'b1100_1100, -1, "R11 fields captured at grant");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_ack();
        t_nak_stall();
        t_fc();
        t_pm();
        t_all_three();
        t_fc_pm();
        t_no_preempt();
        t_capture();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule